// File: doc/BRIEF.md
# Performance Counter Overflow Interrupt Combiner

This block gathers the overflow condition of a bank of event counters plus one cycle counter and folds it into a single level-sensitive interrupt request. A matching cross-trigger event line carries the same level. Hardware overflow pulses from the counters land in a sticky overflow status register. Software can also set bits in that register, and clears them. Each counter has its own interrupt-enable bit. Both registers are written through a small register-write port that offers a set view and a clear view of each register.

The event counters are split into two partitions by a boundary value that the hypervisor programs. Counters with an index below the boundary are gated by the main global enable. Counters at or above it are gated by a separate hypervisor-partition enable. The split applies only when the second privilege level is present; otherwise every counter uses the main enable. The cycle counter sits at bit 31 and is always gated by the main enable. Only counter indices below the implemented count `NUM_CNT`, together with bit 31, exist in the registers.

Top module: `pmu_ovf_irq_top`

## Requirements
- R1: The cycle counter (bit 31) contributes to the request exactly when `glb_en`, interrupt-enable bit 31 and overflow status bit 31 are all 1, whatever the partition settings.
- R2: For event counter n, the effective enable is `glb_en` when `hyp_present` is 0 or n < `part_bound`, and `hyp_en` otherwise.
- R3: Event counter n contributes only when its effective enable, its interrupt-enable bit and its overflow status bit are all 1.
- R4: `irq` is a level equal to the OR of all contributions, registered, so that it follows a change of status, enable or control one clock edge later.
- R5: `xtrig_evt` always carries the same value as `irq`.
- R6: An overflow status bit, once set, stays set, and keeps `irq` asserted, until a write of one to that bit through the clear view.
- R7: Bits with an index from `NUM_CNT` to 30 do not exist. They read as 0, writes and pulses to them have no effect, and they never raise `irq`.
- R8: A write with `wr_sel` = 0 sets status bits, 1 clears status bits, 2 sets interrupt-enable bits and 3 clears interrupt-enable bits. Only bits written as one change. `ovf_status` and `int_en` always show the current state of the registers.
- R9: When an overflow pulse and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R10: While `rst_n` is low at a clock edge, the status and interrupt-enable registers and `irq` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Main global counter enable |
| hyp_en | input | 1 | Enable for the hypervisor partition |
| hyp_present | input | 1 | Second privilege level is implemented |
| part_bound | input | 5 | Partition boundary; indices below it are guest counters |
| ovf_pulse | input | 32 | One-cycle overflow pulses per counter, bit 31 for the cycle counter |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register view select (encoding in R8) |
| wr_data | input | 32 | Write data, one bit per counter |
| ovf_status | output | 32 | Current overflow status |
| int_en | output | 32 | Current interrupt-enable bits |
| irq | output | 1 | Level-sensitive interrupt request |
| xtrig_evt | output | 1 | Cross-trigger overflow event level |

## Verification
A status or enable bit held wrongly shows at once on the `ovf_status` and `int_en` readback. A wrong bit in the enable map or in the reduction shows on `irq` and `xtrig_evt` one edge after the stimulus that should have raised or dropped them. The vectors therefore vary a single factor at a time: the partition side, the presence of the second privilege level, a mismatch between status and enable bits, and a bit that does not exist. The directed tests add timing cases: a request that must persist across idle cycles, a request that must drop exactly one edge after a clear, and an overflow pulse that collides with a clear.

// File: rtl/pmu_ovf_pkg.sv
// Shared definitions for the overflow interrupt combiner.
// Assumes a 32-bit counter map with the cycle counter at bit 31.
package pmu_ovf_pkg;

    localparam int unsigned MAP_W    = 32;
    localparam int unsigned CCNT_BIT = 31;

    // Register view selected by a write
    typedef enum logic [1:0] {
        SEL_OVF_SET = 2'd0,
        SEL_OVF_CLR = 2'd1,
        SEL_IEN_SET = 2'd2,
        SEL_IEN_CLR = 2'd3
    } reg_sel_e;

    // Mask of implemented bits: indices below n_cnt plus the cycle counter
    function automatic logic [MAP_W-1:0] impl_mask(input int unsigned n_cnt);
        logic [MAP_W-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < CCNT_BIT; i++) begin
            if (i < n_cnt) m[i] = 1'b1;
        end
        m[CCNT_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pmu_ovf_wr_decode.sv
// Decodes the register-write port into per-register set and clear vectors.
// Assumes writes are single-cycle strobes. Unimplemented bits are masked here.
module pmu_ovf_wr_decode
    import pmu_ovf_pkg::*;
#(
    parameter int unsigned NUM_CNT = 6,
    localparam logic [MAP_W-1:0] MASK = impl_mask(NUM_CNT)
) (
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [MAP_W-1:0] wr_data,
    output logic [MAP_W-1:0] ovf_set_sw,
    output logic [MAP_W-1:0] ovf_clr_sw,
    output logic [MAP_W-1:0] ien_set_sw,
    output logic [MAP_W-1:0] ien_clr_sw
);

    logic [MAP_W-1:0] data_m;

    // Drop writes to bits that are not implemented
    always_comb data_m = wr_data & MASK;

    // Steer the masked data to the selected view
    always_comb begin
        ovf_set_sw = '0;
        ovf_clr_sw = '0;
        ien_set_sw = '0;
        ien_clr_sw = '0;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_OVF_SET: ovf_set_sw = data_m;
                SEL_OVF_CLR: ovf_clr_sw = data_m;
                SEL_IEN_SET: ien_set_sw = data_m;
                SEL_IEN_CLR: ien_clr_sw = data_m;
                default:     ovf_set_sw = '0;
            endcase
        end
    end

endmodule

// File: rtl/pmu_ovf_sticky_reg.sv
// Bit-wise sticky register with set and clear inputs where set wins.
// Assumes set and clear are already masked to implemented bits.
module pmu_ovf_sticky_reg #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] q
);

    // Hold, clear, then set, so that a set in the same cycle is never lost
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_i) | set_i;
    end

endmodule

// File: rtl/pmu_ovf_enable_map.sv
// Builds the effective enable for each counter index from the partition controls.
// Assumes part_bound is compared unsigned against the counter index.
module pmu_ovf_enable_map
    import pmu_ovf_pkg::*;
#(
    parameter int unsigned NUM_CNT = 6
) (
    input  logic             glb_en,
    input  logic             hyp_en,
    input  logic             hyp_present,
    input  logic [4:0]       part_bound,
    output logic [MAP_W-1:0] eff_en
);

    genvar gi;
    generate
        for (gi = 0; gi < CCNT_BIT; gi++) begin : g_evt
            if (gi < NUM_CNT) begin : g_impl
                localparam logic [4:0] IDX = 5'(gi);
                // Choose the partition enable for this event counter
                always_comb eff_en[gi] = (!hyp_present || (IDX < part_bound)) ? glb_en : hyp_en;
            end else begin : g_absent
                // Index not implemented: never enabled
                always_comb eff_en[gi] = 1'b0;
            end
        end
    endgenerate

    // The cycle counter always follows the main enable
    always_comb eff_en[CCNT_BIT] = glb_en;

endmodule

// File: rtl/pmu_ovf_irq_reduce.sv
// ANDs status, interrupt-enable and effective enable per bit, ORs them, and registers the result.
// Assumes all inputs are synchronous to clk.
module pmu_ovf_irq_reduce #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] status,
    input  logic [WIDTH-1:0] ien,
    input  logic [WIDTH-1:0] eff_en,
    output logic             irq_q,
    output logic             xtrig_q
);

    logic [WIDTH-1:0] contrib;
    logic             any_hit;

    // Per-counter contribution
    always_comb contrib = status & ien & eff_en;

    // Combined request level
    always_comb any_hit = |contrib;

    // Register the request and the cross-trigger level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q   <= 1'b0;
            xtrig_q <= 1'b0;
        end else begin
            irq_q   <= any_hit;
            xtrig_q <= any_hit;
        end
    end

endmodule

// File: rtl/pmu_ovf_irq_top.sv
// Overflow interrupt combiner top: write decode, status and enable registers,
// the partition enable map and the registered request.
// Assumes overflow pulses are one cycle wide and synchronous to clk.
module pmu_ovf_irq_top
    import pmu_ovf_pkg::*;
#(
    parameter int unsigned NUM_CNT = 6,
    localparam logic [MAP_W-1:0] MASK = impl_mask(NUM_CNT)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        glb_en,
    input  logic        hyp_en,
    input  logic        hyp_present,
    input  logic [4:0]  part_bound,
    input  logic [31:0] ovf_pulse,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] ovf_status,
    output logic [31:0] int_en,
    output logic        irq,
    output logic        xtrig_evt
);

    logic [MAP_W-1:0] ovf_set_sw, ovf_clr_sw, ien_set_sw, ien_clr_sw;
    logic [MAP_W-1:0] ovf_set_all;
    logic [MAP_W-1:0] eff_en;

    pmu_ovf_wr_decode #(.NUM_CNT(NUM_CNT)) dec_i (
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .ovf_set_sw (ovf_set_sw),
        .ovf_clr_sw (ovf_clr_sw),
        .ien_set_sw (ien_set_sw),
        .ien_clr_sw (ien_clr_sw)
    );

    // Merge hardware pulses on implemented bits with software sets
    always_comb ovf_set_all = (ovf_pulse & MASK) | ovf_set_sw;

    pmu_ovf_sticky_reg #(.WIDTH(MAP_W)) ovf_reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ovf_set_all),
        .clr_i (ovf_clr_sw),
        .q     (ovf_status)
    );

    pmu_ovf_sticky_reg #(.WIDTH(MAP_W)) ien_reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ien_set_sw),
        .clr_i (ien_clr_sw),
        .q     (int_en)
    );

    pmu_ovf_enable_map #(.NUM_CNT(NUM_CNT)) map_i (
        .glb_en      (glb_en),
        .hyp_en      (hyp_en),
        .hyp_present (hyp_present),
        .part_bound  (part_bound),
        .eff_en      (eff_en)
    );

    pmu_ovf_irq_reduce #(.WIDTH(MAP_W)) red_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .status  (ovf_status),
        .ien     (int_en),
        .eff_en  (eff_en),
        .irq_q   (irq),
        .xtrig_q (xtrig_evt)
    );

endmodule

// File: rtl/pmu_ovf_irq_chk.sv
// Assertion checker for the overflow interrupt combiner, bound to the top module.
module pmu_ovf_irq_chk
    import pmu_ovf_pkg::*;
#(
    parameter int unsigned NUM_CNT = 6,
    localparam logic [MAP_W-1:0] MASK = impl_mask(NUM_CNT)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        glb_en,
    input logic        hyp_present,
    input logic [31:0] ovf_pulse,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic [31:0] ovf_status,
    input logic [31:0] int_en,
    input logic        irq,
    input logic        xtrig_evt
);

    // R1
    ccnt_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && ovf_status[31] && int_en[31]) |=> irq);

    // R2
    guest_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hyp_present && glb_en && ((ovf_status & int_en & MASK) != '0)) |=> irq);

    // R4
    quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf_status & int_en) == '0) |=> !irq);

    // R5
    xtrig_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xtrig_evt == irq);

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 2'd1) |=> ((ovf_status & $past(ovf_status)) == $past(ovf_status)));

    // R9
    pulse_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf_pulse & MASK) != '0) |=> ((ovf_status & $past(ovf_pulse & MASK)) == $past(ovf_pulse & MASK)));

    // R7
    absent_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf_status & ~MASK) == '0) && ((int_en & ~MASK) == '0));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (ovf_status == '0 && int_en == '0 && !irq));

endmodule

bind pmu_ovf_irq_top pmu_ovf_irq_chk #(.NUM_CNT(NUM_CNT)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .glb_en      (glb_en),
    .hyp_present (hyp_present),
    .ovf_pulse   (ovf_pulse),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .ovf_status  (ovf_status),
    .int_en      (int_en),
    .irq         (irq),
    .xtrig_evt   (xtrig_evt)
);

// File: tb/pmu_ovf_irq_top_tb_top.sv
// Self-checking bench: vector table for the enable and partition logic, then directed tests.
module pmu_ovf_irq_top_tb_top;

    localparam int unsigned NCNT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glb_en = 1'b0, hyp_en = 1'b0, hyp_present = 1'b0;
    logic [4:0]  part_bound = '0;
    logic [31:0] ovf_pulse = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] ovf_status, int_en;
    logic        irq, xtrig_evt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pmu_ovf_irq_top #(.NUM_CNT(NCNT)) dut_i (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .hyp_en(hyp_en),
        .hyp_present(hyp_present), .part_bound(part_bound), .ovf_pulse(ovf_pulse),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ovf_status(ovf_status), .int_en(int_en), .irq(irq), .xtrig_evt(xtrig_evt)
    );

    typedef struct packed {
        logic        g;
        logic        h;
        logic        p;
        logic [4:0]  b;
        logic [31:0] st;
        logic [31:0] ie;
        logic        exp;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{g:1'b1, h:1'b0, p:1'b1, b:5'd0, st:32'h8000_0000, ie:32'h8000_0000, exp:1'b1}, // R1
        '{g:1'b0, h:1'b1, p:1'b1, b:5'd0, st:32'h8000_0000, ie:32'h8000_0000, exp:1'b0}, // R1
        '{g:1'b1, h:1'b0, p:1'b1, b:5'd4, st:32'h0000_0004, ie:32'h0000_0004, exp:1'b1}, // R2
        '{g:1'b0, h:1'b1, p:1'b1, b:5'd4, st:32'h0000_0004, ie:32'h0000_0004, exp:1'b0}, // R2
        '{g:1'b0, h:1'b1, p:1'b1, b:5'd4, st:32'h0000_0020, ie:32'h0000_0020, exp:1'b1}, // R2
        '{g:1'b1, h:1'b0, p:1'b1, b:5'd4, st:32'h0000_0020, ie:32'h0000_0020, exp:1'b0}, // R2
        '{g:1'b1, h:1'b0, p:1'b0, b:5'd4, st:32'h0000_0020, ie:32'h0000_0020, exp:1'b1}, // R2
        '{g:1'b1, h:1'b1, p:1'b1, b:5'd8, st:32'h0000_0008, ie:32'h0000_0004, exp:1'b0}, // R3
        '{g:1'b1, h:1'b1, p:1'b1, b:5'd8, st:32'h0000_0400, ie:32'h0000_0400, exp:1'b0}, // R7
        '{g:1'b0, h:1'b1, p:1'b1, b:5'd0, st:32'h0000_0001, ie:32'h0000_0001, exp:1'b1}  // R2
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(ovf_status == '0 && int_en == '0, "R10", ovf_status | int_en, 32'h0);
        check(irq == 1'b0, "R10", {31'd0, irq}, 32'h0);
        rst_n = 1'b1;

        // Vector table: R1, R2, R3, R5, R7
        foreach (VEC[i]) begin
            wr(2'd1, 32'hFFFF_FFFF);
            wr(2'd3, 32'hFFFF_FFFF);
            glb_en = VEC[i].g; hyp_en = VEC[i].h;
            hyp_present = VEC[i].p; part_bound = VEC[i].b;
            wr(2'd2, VEC[i].ie);
            wr(2'd0, VEC[i].st);
            @(negedge clk);
            check(irq == VEC[i].exp, $sformatf("R3 vec%0d", i), {31'd0, irq}, {31'd0, VEC[i].exp});
            check(xtrig_evt == irq, "R5", {31'd0, xtrig_evt}, {31'd0, irq});
        end

        // R7: absent bits read as zero after set writes and pulses
        wr(2'd0, 32'h7FFF_FFC0);
        wr(2'd2, 32'h0000_0C00);
        check((ovf_status & 32'h7FFF_FFC0) == '0, "R7", ovf_status, 32'h0);
        check((int_en & 32'h7FFF_FFC0) == '0, "R7", int_en, 32'h0);

        // R8: set and clear views of interrupt-enable, zeros leave bits alone
        wr(2'd3, 32'hFFFF_FFFF);
        wr(2'd2, 32'h0000_0003);
        check(int_en == 32'h0000_0003, "R8", int_en, 32'h3);
        wr(2'd3, 32'h0000_0001);
        check(int_en == 32'h0000_0002, "R8", int_en, 32'h2);
        wr(2'd2, 32'h0000_0000);
        check(int_en == 32'h0000_0002, "R8", int_en, 32'h2);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'h0000_0011);
        wr(2'd1, 32'h0000_0010);
        check(ovf_status == 32'h0000_0001, "R8", ovf_status, 32'h1);

        // R6 and R4: a pulse raises a sticky request that drops one edge after a clear
        wr(2'd1, 32'hFFFF_FFFF);
        glb_en = 1'b1; hyp_present = 1'b0;
        wr(2'd2, 32'h0000_0002);
        @(negedge clk);
        ovf_pulse = 32'h0000_0002;
        @(negedge clk);
        ovf_pulse = '0;
        check(irq == 1'b0, "R4", {31'd0, irq}, 32'h0);
        @(negedge clk);
        check(irq == 1'b1, "R4", {31'd0, irq}, 32'h1);
        repeat (5) @(negedge clk);
        check(irq == 1'b1 && ovf_status[1], "R6", {31'd0, irq}, 32'h1);
        wr(2'd1, 32'h0000_0002);
        check(irq == 1'b1, "R4", {31'd0, irq}, 32'h1);
        @(negedge clk);
        check(irq == 1'b0, "R6", {31'd0, irq}, 32'h0);

        // R9: a pulse and a clear on the same bit in one cycle leave it set
        @(negedge clk);
        ovf_pulse = 32'h0000_0004;
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'h0000_0004;
        @(negedge clk);
        ovf_pulse = '0; wr_en = 1'b0; wr_data = '0;
        check(ovf_status[2] == 1'b1, "R9", ovf_status, 32'h4);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule